// File: doc/BRIEF.md
# Flash Program/Erase Status Read Path

This block sits on the read path of a flash-style memory model. An operation engine launches either a word program or an erase. The block times the operation with a cycle counter and drives the busy flag. While the operation runs, a read returns a status word in place of array data. The status word carries two completion indicators side by side. Bit 7 is a data-complement flag: it holds the inverse of bit 7 of the word being written, or 0 during an erase, because 1 is the erased value. Bit 6 is a toggle flag that inverts on every read for as long as the operation is busy.

When the block is idle, a read returns the array word presented on its input. In identification mode it returns one of three values instead: a fixed manufacturer code, a fixed device code, or a boot-lock status word. The program and erase durations are parameters given as clock-cycle counts. Defaults model roughly 30 µs and 5 s at 100 MHz.

Top module: `flash_status_read`

## Requirements
- R1: After reset, busy_o is 0 and rd_data_o is 0x0000.
- R2: A start_prog_i pulse while idle raises busy_o for exactly PROG_CYCLES cycles, beginning at the next clock. A start_erase_i pulse does the same for ERASE_CYCLES cycles. If both pulses arrive in the same cycle, the erase is taken.
- R3: A start pulse received while busy_o is high has no effect: the running operation keeps its kind, its remaining length and its latched data.
- R4: During a word program, a read returns on bit 7 the inverse of bit 7 of prog_data_i as sampled with the start pulse.
- R5: During an erase, a read returns 0 on bit 7.
- R6: While busy, bit 6 reads 0 on the first read after a start and inverts on each further read. Bits 15:8 and 5:0 read 0 while busy.
- R7: When idle and not in identification mode, a read returns array_data_i. Reads while idle do not advance the toggle flag.
- R8: In identification mode while idle, address 0 reads 0x001F and address 1 reads 0x0088.
- R9: In identification mode while idle, address 2 reads boot_locked_i on bit 0 (1 means locked, 0 means programmable), with all other bits 0. Any other address reads 0x0000.
- R10: rd_data_o takes the value selected for a read one clock after rd_i is sampled high. It holds that value in cycles without a read.
- R11: While busy, status takes priority over identification mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_prog_i | input | 1 | Launch a word program (one-cycle pulse) |
| start_erase_i | input | 1 | Launch an erase (one-cycle pulse) |
| prog_data_i | input | 16 | Word being programmed, sampled with start_prog_i |
| rd_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Read address |
| array_data_i | input | 16 | Array word at addr_i |
| id_mode_i | input | 1 | Identification mode select |
| boot_locked_i | input | 1 | Boot-region lock state |
| busy_o | output | 1 | Operation in progress |
| rd_data_o | output | 16 | Registered read data |

## Verification
Some properties are checked on every cycle by the assertions. A busy operation cannot end while count remains, and a start pulse during busy cannot change the operation kind. Status words carry zero in their unused bits, and bit 7 is zero during an erase. Bit 6 alternates across back-to-back busy reads, the identification codes appear at their addresses, and read data holds between reads. Other behaviour can only be shown by the bench's scenarios, which compare against a cycle-level reference model. These are the exact busy length of each operation kind, the erase-wins rule for simultaneous starts, and the complement of the data latched at start. They also include the toggle restarting at 0 for each new operation, status taking priority over identification mode, and the return of array data on the first read after completion.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;
  typedef enum logic {
    OP_PROG  = 1'b0,
    OP_ERASE = 1'b1
  } op_e;

  localparam logic [15:0] MFR_CODE = 16'h001F;
  localparam logic [15:0] DEV_CODE = 16'h0088;
  localparam int          ID_MFR_ADDR  = 0;
  localparam int          ID_DEV_ADDR  = 1;
  localparam int          ID_LOCK_ADDR = 2;
  localparam int          DATA_W       = 16;
  localparam int          DPOLL_BIT    = 7;
  localparam int          TOGGLE_BIT   = 6;
endpackage

// File: rtl/fsr_op_timer.sv
module fsr_op_timer
  import flash_status_pkg::*;
#(
  parameter int PROG_CYCLES  = 3000,
  parameter int ERASE_CYCLES = 500_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_prog_i,
  input  logic start_erase_i,
  output logic launch_o,
  output logic busy_o,
  output op_e  op_o
);
  localparam int MAX_CYC = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
  localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC + 1) : 1;

  logic [CNT_W-1:0] cnt_q;

  assign launch_o = !busy_o && (start_prog_i || start_erase_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      op_o   <= OP_PROG;
      cnt_q  <= '0;
    end else if (launch_o) begin
      busy_o <= 1'b1;
      // erase wins a simultaneous start
      op_o   <= start_erase_i ? OP_ERASE : OP_PROG;
      cnt_q  <= start_erase_i ? CNT_W'(ERASE_CYCLES - 1) : CNT_W'(PROG_CYCLES - 1);
    end else if (busy_o) begin
      if (cnt_q == '0) busy_o <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assert_busy_holds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && cnt_q != '0 |=> busy_o);

  assert_start_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && (start_prog_i || start_erase_i) |=> op_o == $past(op_o));
endmodule

// File: rtl/fsr_status_gen.sv
module fsr_status_gen
  import flash_status_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic [DATA_W-1:0] prog_data_i,
  input  logic              busy_i,
  input  op_e               op_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] status_o
);
  logic wbit_q;
  logic toggle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbit_q   <= 1'b0;
      toggle_q <= 1'b0;
    end else if (launch_i) begin
      wbit_q   <= prog_data_i[DPOLL_BIT];
      toggle_q <= 1'b0;
    end else if (busy_i && rd_i) begin
      toggle_q <= ~toggle_q;
    end
  end

  always_comb begin
    status_o             = '0;
    status_o[DPOLL_BIT]  = (op_i == OP_ERASE) ? 1'b0 : ~wbit_q;
    status_o[TOGGLE_BIT] = toggle_q;
  end

  assert_toggle_frozen_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i && !launch_i |=> $stable(toggle_q));
endmodule

// File: rtl/fsr_id_mux.sv
module fsr_id_mux
  import flash_status_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              boot_locked_i,
  output logic [DATA_W-1:0] id_word_o
);
  always_comb begin
    id_word_o = '0;
    if (addr_i == ADDR_W'(ID_MFR_ADDR))       id_word_o = MFR_CODE;
    else if (addr_i == ADDR_W'(ID_DEV_ADDR))  id_word_o = DEV_CODE;
    else if (addr_i == ADDR_W'(ID_LOCK_ADDR)) id_word_o[0] = boot_locked_i;
  end
endmodule

// File: rtl/flash_status_read.sv
module flash_status_read
  import flash_status_pkg::*;
#(
  parameter int ADDR_W       = 17,
  parameter int PROG_CYCLES  = 3000,
  parameter int ERASE_CYCLES = 500_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_prog_i,
  input  logic              start_erase_i,
  input  logic [15:0]       prog_data_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       array_data_i,
  input  logic              id_mode_i,
  input  logic              boot_locked_i,
  output logic              busy_o,
  output logic [15:0]       rd_data_o
);
  logic              launch;
  op_e               op;
  logic [DATA_W-1:0] status_word;
  logic [DATA_W-1:0] id_word;

  fsr_op_timer #(
    .PROG_CYCLES (PROG_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES)
  ) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_prog_i (start_prog_i),
    .start_erase_i(start_erase_i),
    .launch_o     (launch),
    .busy_o       (busy_o),
    .op_o         (op)
  );

  fsr_status_gen u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .launch_i   (launch),
    .prog_data_i(prog_data_i),
    .busy_i     (busy_o),
    .op_i       (op),
    .rd_i       (rd_i),
    .status_o   (status_word)
  );

  fsr_id_mux #(.ADDR_W(ADDR_W)) u_id (
    .addr_i       (addr_i),
    .boot_locked_i(boot_locked_i),
    .id_word_o    (id_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rd_data_o <= '0;
    else if (rd_i) begin
      if (busy_o)         rd_data_o <= status_word;
      else if (id_mode_i) rd_data_o <= id_word;
      else                rd_data_o <= array_data_i;
    end
  end

  assert_erase_bit7_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && busy_o && op == OP_ERASE |=> !rd_data_o[7]);

  assert_status_unused_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && busy_o |=> rd_data_o[15:8] == 8'h00 && rd_data_o[5:0] == 6'h00);

  assert_toggle_alternates_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && busy_o && $past(rd_i && busy_o) |=> rd_data_o[6] != $past(rd_data_o[6]));

  assert_mfr_code_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !busy_o && id_mode_i && addr_i == '0 |=> rd_data_o == 16'h001F);

  assert_dev_code_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !busy_o && id_mode_i && addr_i == ADDR_W'(1) |=> rd_data_o == 16'h0088);

  assert_hold_without_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rd_data_o));
endmodule

// File: tb/flash_status_read_test.sv
module flash_status_read_test;
  localparam int ADDR_W = 17;
  localparam int PROG_N = 12;
  localparam int ERASE_N = 40;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_prog = 1'b0;
  logic              start_erase = 1'b0;
  logic [15:0]       pdata = '0;
  logic              rd = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [15:0]       array_w;
  logic              id_mode = 1'b0;
  logic              locked = 1'b0;
  logic              busy;
  logic [15:0]       rdata;

  always #2.5 clk = ~clk;

  assign array_w = addr[15:0] ^ 16'h5A3C;

  flash_status_read #(
    .ADDR_W(ADDR_W), .PROG_CYCLES(PROG_N), .ERASE_CYCLES(ERASE_N)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_prog_i(start_prog), .start_erase_i(start_erase),
    .prog_data_i(pdata), .rd_i(rd), .addr_i(addr), .array_data_i(array_w),
    .id_mode_i(id_mode), .boot_locked_i(locked), .busy_o(busy), .rd_data_o(rdata)
  );

  // behavioural reference model
  int          m_rem = 0;
  logic        m_busy = 1'b0;
  logic        m_erase = 1'b0;
  logic [15:0] m_wd = '0;
  logic        m_tog = 1'b0;
  logic [15:0] m_rd = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rem <= 0; m_busy <= 1'b0; m_erase <= 1'b0; m_wd <= '0; m_tog <= 1'b0; m_rd <= '0;
    end else begin
      if (rd) begin
        if (m_busy) begin
          m_rd  <= {8'h00, (m_erase ? 1'b0 : ~m_wd[7]), m_tog, 6'h00};
          m_tog <= ~m_tog;
        end else if (id_mode) begin
          if (addr == 0)      m_rd <= 16'h001F;
          else if (addr == 1) m_rd <= 16'h0088;
          else if (addr == 2) m_rd <= {15'h0, locked};
          else                m_rd <= 16'h0000;
        end else m_rd <= array_w;
      end
      if (m_busy) begin
        if (m_rem == 1) m_busy <= 1'b0;
        m_rem <= m_rem - 1;
      end else if (start_erase) begin
        m_busy <= 1'b1; m_rem <= ERASE_N; m_erase <= 1'b1; m_tog <= 1'b0;
      end else if (start_prog) begin
        m_busy <= 1'b1; m_rem <= PROG_N; m_erase <= 1'b0; m_tog <= 1'b0; m_wd <= pdata;
      end
    end
  end

  int    n_chk = 0;
  int    n_bad = 0;
  string req = "R1";
  bit    done = 1'b0;
  int    cyc = 0;

  always @(negedge clk) begin
    if (!done) begin
      n_chk++;
      if (busy !== m_busy || rdata !== m_rd) begin
        n_bad++;
        $display("FAIL %s busy=%b exp %b rd_data=%h exp %h", req, busy, m_busy, rdata, m_rd);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog busy=%b exp 0 rd_data=%h exp %h", busy, rdata, m_rd);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic read(input int a);
    @(negedge clk); rd = 1'b1; addr = ADDR_W'(a);
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic go(input bit p, input bit e, input logic [15:0] d);
    @(negedge clk); start_prog = p; start_erase = e; pdata = d;
    @(negedge clk); start_prog = 1'b0; start_erase = 1'b0; pdata = 16'hFFFF;
  endtask

  task automatic read_burst(input int n, input int a);
    @(negedge clk); rd = 1'b1; addr = ADDR_W'(a);
    idle(n);
    rd = 1'b0;
  endtask

  initial begin
    req = "R1"; idle(3);
    rst_n = 1'b1; idle(2);
    req = "R7 R10"; read(5); idle(2); read(17'h1ABCD); read(0); idle(1);
    req = "R8 R9"; id_mode = 1'b1;
    read(0); read(1); read(2); locked = 1'b1; read(2); read(7); idle(1);
    id_mode = 1'b0;
    req = "R2 R4 R6"; go(1, 0, 16'h0080); read_burst(16, 3); idle(2);
    req = "R4 R7"; go(1, 0, 16'h1234); read(9); idle(3); read_burst(12, 9);
    read_burst(3, 4);
    req = "R3"; go(0, 1, 16'h0000); idle(5); go(1, 0, 16'h00FF); idle(3);
    go(1, 1, 16'h0000); read_burst(4, 1); idle(ERASE_N);
    req = "R5 R6 R10"; go(0, 1, 16'h0); read(2); idle(4); read(2); read(2); idle(3);
    read_burst(ERASE_N, 2);
    req = "R2"; go(1, 1, 16'h0055); read_burst(ERASE_N + 3, 6);
    req = "R11"; id_mode = 1'b1; go(1, 0, 16'h0000); read_burst(PROG_N + 3, 0);
    id_mode = 1'b0;
    idle(3);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule